// File: doc/BRIEF.md
# Flash Write-Cycle Protection Gate

This block stands between the external bus strobes of a parallel flash device and its command state machine. It decides which bus write cycles become command writes. The chip-enable, output-enable and write-enable strobes, all active low, are brought into the clock domain and filtered so that pulses shorter than a set number of sample clocks have no effect. A cycle counts as a write only when chip-enable and write-enable are low and output-enable is high. The block issues a one-clock command write strobe when such a cycle ends.

The block also handles the supply and reset side of write protection. While a low-supply lockout flag or a power-on-reset flag is active, the command logic is held in reset and no write is issued. If a write condition is already present on the pins when either flag clears, the end of that cycle is not treated as a command. A detector flag for a high voltage on the reset pin raises a temporary unprotect override. The override masks the stored sector protection bits to zero. When the flag drops, the stored protection shows through again unchanged.

Top module: `flash_wr_gate`

## Requirements
- R1: A write cycle is in progress only while the filtered ce_n is 0, we_n is 0 and oe_n is 1. oe_n at 0, ce_n at 1 or we_n at 1 each prevent a write.
- R2: wr_stb is high for exactly one clock when an accepted write cycle ends (trailing edge). It comes within FILT_LEN+6 clocks of the pin change, and each cycle gives exactly one pulse.
- R3: A low pulse on ce_n, we_n or oe_n that lasts fewer than FILT_LEN clocks is ignored. A pulse of FILT_LEN clocks or more is taken.
- R4: While lockout is 1, cmd_rst is 1 and no wr_stb is issued.
- R5: While por is 1, or while rst_n is 0, cmd_rst is 1. cmd_rst is 0 once both flags are clear.
- R6: If a write condition is held on the pins when por clears, the end of that cycle gives no wr_stb. The next complete write gives a wr_stb as normal.
- R7: A write condition held while lockout clears is suppressed in the same way as in R6.
- R8: While hv_det is 1 (after two clocks of synchronisation), unprot_ovr is 1 and prot_eff is all zeros.
- R9: After hv_det returns to 0, unprot_ovr is 0 and prot_eff equals sect_prot again, bit for bit.
- R10: During reset, wr_stb is 0, cmd_rst is 1, unprot_ovr is 0 and prot_eff equals sect_prot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip-enable strobe from the bus, active low |
| oe_n | input | 1 | Output-enable strobe from the bus, active low |
| we_n | input | 1 | Write-enable strobe from the bus, active low |
| lockout | input | 1 | Low-supply lockout flag, active high |
| por | input | 1 | Power-on reset in progress, active high |
| hv_det | input | 1 | High voltage detected on the reset pin, active high |
| sect_prot | input | NSECT | Stored sector protection bits, 1 = protected |
| wr_stb | output | 1 | One-clock qualified command write strobe |
| cmd_rst | output | 1 | Reset to the command logic (return to array read) |
| unprot_ovr | output | 1 | Temporary sector-unprotect override active |
| prot_eff | output | NSECT | Protection bits after the override mask |

## Verification
The assertions assume that rst_n is the only reset and that every other input may change at any time. Each flag and strobe is sampled only through the synchroniser stages. The delay checks therefore count on a fixed two-flop latency with no metastable settling. The bench changes every input on the falling clock edge and holds each strobe level for a whole number of clocks, so each glitch width is an exact number of samples that sits either side of the threshold.

// File: rtl/wg_pkg.sv
package wg_pkg;
  // bit positions of the strobes inside the synchronised strobe vector
  typedef enum int unsigned {
    STB_CE = 0,
    STB_OE = 1,
    STB_WE = 2
  } stb_idx_e;

  localparam int unsigned NSTB = 3;
endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/wg_filter.sv
module wg_filter #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_in,
  output logic f_out
);
  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    out_d  = out_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (s_in == out_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      out_d = s_in;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RST_VAL;
      cnt_q <= '0;
    end else if (cnt_en) begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign f_out = out_q;

  // R3: the output can only move to the level that was sampled just before
  assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> ($past(s_in) == out_q));
endmodule

// File: rtl/wg_qualify.sv
module wg_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_f,
  input  logic oe_f,
  input  logic we_f,
  input  logic lock_s,
  input  logic por_s,
  output logic wr_stb
);
  logic eff;
  logic eff_q, eff_d;
  logic inhib_q, inhib_d;
  logic stb_q, stb_d;

  // write cycle present: both enables low, output enable high
  assign eff = ~ce_f & ~we_f & oe_f;

  always_comb begin
    eff_d = eff;
    if (por_s || lock_s) begin
      inhib_d = 1'b1;
    end else if (we_f || ce_f) begin
      inhib_d = 1'b0;
    end else begin
      inhib_d = inhib_q;
    end
    stb_d = eff_q & ~eff & ~inhib_q & ~lock_s & ~por_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= 1'b0;
      inhib_q <= 1'b1;
      stb_q   <= 1'b0;
    end else begin
      eff_q   <= eff_d;
      inhib_q <= inhib_d;
      stb_q   <= stb_d;
    end
  end

  assign wr_stb = stb_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_lock_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> !wr_stb);
  assert_por_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> !wr_stb);
  // R1: a strobe always follows a cycle in which output enable was high
  assert_oe_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(eff_q));
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned NSECT    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             lockout,
  input  logic             por,
  input  logic             hv_det,
  input  logic [NSECT-1:0] sect_prot,
  output logic             wr_stb,
  output logic             cmd_rst,
  output logic             unprot_ovr,
  output logic [NSECT-1:0] prot_eff
);
  import wg_pkg::*;

  logic            rst_int_n;
  logic [NSTB-1:0] stb_raw, stb_s, stb_f;
  logic            lock_s, por_s, hv_s;

  // asynchronous assert, synchronous release
  wg_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_int_n)
  );

  assign stb_raw[STB_CE] = ce_n;
  assign stb_raw[STB_OE] = oe_n;
  assign stb_raw[STB_WE] = we_n;

  wg_sync #(.W(NSTB), .RST_VAL({NSTB{1'b1}})) u_stb_sync (
    .clk(clk), .rst_n(rst_int_n), .din(stb_raw), .dout(stb_s)
  );

  wg_sync #(.W(3), .RST_VAL(3'b011)) u_flag_sync (
    .clk(clk), .rst_n(rst_int_n), .din({hv_det, por, lockout}),
    .dout({hv_s, por_s, lock_s})
  );

  for (genvar gi = 0; gi < NSTB; gi++) begin : g_filt
    wg_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_int_n), .s_in(stb_s[gi]), .f_out(stb_f[gi])
    );
  end

  wg_qualify u_qual (
    .clk(clk), .rst_n(rst_int_n),
    .ce_f(stb_f[STB_CE]), .oe_f(stb_f[STB_OE]), .we_f(stb_f[STB_WE]),
    .lock_s(lock_s), .por_s(por_s), .wr_stb(wr_stb)
  );

  assign cmd_rst    = lock_s | por_s;
  assign unprot_ovr = hv_s;
  assign prot_eff   = sect_prot & ~{NSECT{hv_s}};

  // R8 / R9: the override follows the pin flag after two clocks
  assert_ovr_delay_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(unprot_ovr) |-> ($past(hv_det, 2) == unprot_ovr));
  assert_prot_restore_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !unprot_ovr |-> (prot_eff == sect_prot));
endmodule

// File: tb/flash_wr_gate_bench.sv
module flash_wr_gate_bench;
  localparam int unsigned FILT_LEN = 3;
  localparam int unsigned NSECT    = 8;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, lockout, por, hv_det;
  logic [NSECT-1:0] sect_prot;
  logic wr_stb, cmd_rst, unprot_ovr;
  logic [NSECT-1:0] prot_eff;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int doubles = 0;
  logic prev_stb = 1'b0;

  always #10 clk = ~clk;

  flash_wr_gate #(.FILT_LEN(FILT_LEN), .NSECT(NSECT)) u_flash_wr_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .lockout(lockout), .por(por), .hv_det(hv_det), .sect_prot(sect_prot),
    .wr_stb(wr_stb), .cmd_rst(cmd_rst), .unprot_ovr(unprot_ovr), .prot_eff(prot_eff)
  );

  always @(negedge clk) begin
    if (wr_stb) pulses++;
    if (wr_stb && prev_stb) doubles++;
    prev_stb = wr_stb;
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {we low clocks[3:0], ce_n, oe_n, lockout, expected strobes[1:0]}
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd5, 1'b0, 1'b1, 1'b0, 2'd1},  // R1 R2 plain write
    {4'd3, 1'b0, 1'b1, 1'b0, 2'd1},  // R3 width at threshold
    {4'd2, 1'b0, 1'b1, 1'b0, 2'd0},  // R3 one below threshold
    {4'd1, 1'b0, 1'b1, 1'b0, 2'd0},  // R3 single sample
    {4'd5, 1'b1, 1'b1, 1'b0, 2'd0},  // R1 chip enable high
    {4'd5, 1'b0, 1'b0, 1'b0, 2'd0},  // R1 output enable low
    {4'd5, 1'b0, 1'b1, 1'b1, 2'd0},  // R4 lockout
    {4'd8, 1'b0, 1'b1, 1'b0, 2'd1}   // R2 long write
  };

  initial begin
    int base;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    lockout = 1'b0; por = 1'b0; hv_det = 1'b0; sect_prot = 8'hA5;
    idle(4);
    // R10 reset state
    check("R10 wr_stb", wr_stb, 0);
    check("R10 cmd_rst", cmd_rst, 1);
    check("R10 unprot_ovr", unprot_ovr, 0);
    check("R10 prot_eff", prot_eff, 8'hA5);
    rst_n = 1'b1;
    idle(10);
    check("R5 cmd_rst clear", cmd_rst, 0);

    for (int i = 0; i < NVEC; i++) begin
      ce_n = VEC[i][4]; oe_n = VEC[i][3]; lockout = VEC[i][2];
      idle(8);
      if (VEC[i][2]) check("R4 cmd_rst in lockout", cmd_rst, 1);
      base = pulses;
      we_n = 1'b0;
      idle(int'(VEC[i][8:5]));
      we_n = 1'b1;
      idle(FILT_LEN + 9);
      check($sformatf("R1/R2/R3/R4 vector %0d", i), pulses - base, VEC[i][1:0]);
      lockout = 1'b0; ce_n = 1'b0; oe_n = 1'b1;
      idle(4);
    end

    // R3 chip-enable glitch with write enable held low
    ce_n = 1'b1; idle(6); we_n = 1'b0; idle(6);
    base = pulses;
    ce_n = 1'b0; idle(FILT_LEN - 1); ce_n = 1'b1; idle(FILT_LEN + 9);
    check("R3 short ce_n glitch", pulses - base, 0);
    base = pulses;
    ce_n = 1'b0; idle(FILT_LEN); ce_n = 1'b1; idle(FILT_LEN + 9);
    check("R3 ce_n pulse at threshold", pulses - base, 1);
    we_n = 1'b1; idle(6); ce_n = 1'b0; idle(6);

    // R3 output-enable glitch inside a held write
    base = pulses;
    we_n = 1'b0; idle(8);
    oe_n = 1'b0; idle(FILT_LEN - 1); oe_n = 1'b1; idle(8);
    check("R3 oe_n glitch does not end write", pulses - base, 0);
    we_n = 1'b1; idle(FILT_LEN + 9);
    check("R3 write after oe_n glitch", pulses - base, 1);

    // R5 R6 power-up with write condition already asserted
    por = 1'b1; idle(4);
    check("R5 cmd_rst during por", cmd_rst, 1);
    we_n = 1'b0; idle(8);
    base = pulses;
    por = 1'b0; idle(10);
    check("R5 cmd_rst after por", cmd_rst, 0);
    we_n = 1'b1; idle(FILT_LEN + 9);
    check("R6 first edge after power-up", pulses - base, 0);
    we_n = 1'b0; idle(6); we_n = 1'b1; idle(FILT_LEN + 9);
    check("R6 next write accepted", pulses - base, 1);

    // R7 lockout released under a held write
    we_n = 1'b0; lockout = 1'b1; idle(8);
    base = pulses;
    lockout = 1'b0; idle(10);
    we_n = 1'b1; idle(FILT_LEN + 9);
    check("R7 edge after lockout suppressed", pulses - base, 0);
    we_n = 1'b0; idle(6); we_n = 1'b1; idle(FILT_LEN + 9);
    check("R7 next write accepted", pulses - base, 1);

    // R8 R9 temporary unprotect
    hv_det = 1'b1; idle(4);
    check("R8 unprot_ovr", unprot_ovr, 1);
    check("R8 prot_eff masked", prot_eff, 0);
    hv_det = 1'b0; idle(4);
    check("R9 unprot_ovr released", unprot_ovr, 0);
    check("R9 prot_eff restored", prot_eff, 8'hA5);

    check("R2 no back-to-back strobes", doubles, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule